// File: doc/BRIEF.md
# Receive Downstream AIS Inserter

This block sits in a receive data path. When downstream AIS is in force, it replaces the received payload word with all ones. AIS can be brought in by the alarm detectors or by hand. Automatic mode is a control input. While it is on, any one of loss of signal, out of frame or incoming AIS asserts downstream AIS. A separate manual control asserts downstream AIS whatever the alarms are doing.

The insertion state is held in a small state machine with three states. `ST_CLEAR` means no AIS. `ST_AUTO` means AIS is held by an alarm under automatic mode. `ST_MANUAL` means AIS is held by the manual control, which has priority. The transitions are:
- `ST_CLEAR` to `ST_MANUAL` on a manual request.
- `ST_CLEAR` to `ST_AUTO` on an alarm while automatic mode is on.
- `ST_AUTO` to `ST_MANUAL` when a manual request arrives.
- `ST_MANUAL` to `ST_AUTO` when manual is released while an automatic trigger still holds.
- `ST_AUTO` or `ST_MANUAL` to `ST_CLEAR` when no trigger remains.

A status output shows whether AIS is active. Every change of state takes effect on the clock edge after the condition that caused it. The data gate follows the registered state with no further delay.

Top module: `rx_ais_inserter`

## Requirements
- R1: After reset the AIS-active output is 0 and the output data equals the input data.
- R2: With automatic mode on, an active loss-of-signal, out-of-frame or AIS-detected input at a clock edge makes the AIS-active output 1 after that edge.
- R3: With the manual control at 1 at a clock edge, the AIS-active output is 1 after that edge, whatever the alarm and automatic-mode inputs are.
- R4: The AIS-active output returns to 0 after the first edge at which the manual control is 0 and no automatic trigger holds. No automatic trigger holds when all three alarms are 0 or automatic mode is off.
- R5: While the AIS-active output is 1, every bit of the output data is 1.
- R6: While the AIS-active output is 0, the output data equals the input data in the same cycle.
- R7: With automatic mode and manual control both 0, the alarm inputs change neither the AIS-active output nor the output data.
- R8: Manual insertion has priority. Releasing the manual control while automatic mode is on and an alarm is present keeps the AIS-active output at 1 with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| los_i | input | 1 | Loss-of-signal alarm |
| oof_i | input | 1 | Out-of-frame alarm |
| ais_det_i | input | 1 | Incoming AIS detected |
| auto_en_i | input | 1 | Automatic AIS mode enable |
| man_ins_i | input | 1 | Manual AIS insertion |
| rx_data_i | input | DATA_W | Received payload word |
| rx_data_o | output | DATA_W | Payload word after AIS gating |
| ais_active_o | output | 1 | Downstream AIS active status |

## Verification
The bench goes after the following corner cases:
- **Removal with auto mode turned off.** It drops automatic mode while an alarm persists. A design that latched the alarm regardless of mode would keep AIS stuck on.
- **Manual release under a live alarm.** It releases manual insertion while an auto-triggered alarm is present. A design that lost priority tracking would open a one-cycle data gap.
- **Alarms with both controls off.** It raises each alarm alone with both controls off. A design that ignored the mode would corrupt payload data.
- **Insertion and removal timing.** It checks the edge on which insertion and removal happen. A design with an extra register stage would be one cycle late.

// File: rtl/ais_pkg.sv
package ais_pkg;
    typedef enum logic [1:0] {
        ST_CLEAR  = 2'd0,
        ST_AUTO   = 2'd1,
        ST_MANUAL = 2'd2
    } ais_state_e;
endpackage

// File: rtl/ais_cause_merge.sv
module ais_cause_merge (
    input  logic los_i,
    input  logic oof_i,
    input  logic ais_det_i,
    input  logic auto_en_i,
    output logic auto_trig_o
);
    logic any_alarm;

    always_comb begin
        any_alarm   = los_i | oof_i | ais_det_i;
        auto_trig_o = auto_en_i & any_alarm;
    end
endmodule

// File: rtl/ais_state_fsm.sv
module ais_state_fsm
    import ais_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_trig_i,
    input  logic       man_ins_i,
    output logic       active_o
);
    ais_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (man_ins_i)        state_d = ST_MANUAL;
                else if (auto_trig_i) state_d = ST_AUTO;
            end
            ST_AUTO: begin
                if (man_ins_i)         state_d = ST_MANUAL;
                else if (!auto_trig_i) state_d = ST_CLEAR;
            end
            ST_MANUAL: begin
                if (!man_ins_i) state_d = auto_trig_i ? ST_AUTO : ST_CLEAR;
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        active_o = (state_q != ST_CLEAR);
    end

    // R3: manual request always leads to active state
    p_manual_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        man_ins_i |=> (state_q == ST_MANUAL));
    // R2: automatic trigger without manual leads to auto state
    p_auto_insert_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_trig_i && !man_ins_i) |=> (state_q == ST_AUTO));
    // R4: no trigger at all clears the state
    p_remove_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_trig_i && !man_ins_i) |=> (state_q == ST_CLEAR));
endmodule

// File: rtl/ais_data_gate.sv
module ais_data_gate #(
    parameter int DATA_W = 8
) (
    input  logic              active_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);
    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    always_comb begin
        data_o = active_i ? ALL_ONES : data_i;
    end
endmodule

// File: rtl/rx_ais_inserter.sv
module rx_ais_inserter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              los_i,
    input  logic              oof_i,
    input  logic              ais_det_i,
    input  logic              auto_en_i,
    input  logic              man_ins_i,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              ais_active_o
);
    logic auto_trig;
    logic active;

    ais_cause_merge u_merge (
        .los_i      (los_i),
        .oof_i      (oof_i),
        .ais_det_i  (ais_det_i),
        .auto_en_i  (auto_en_i),
        .auto_trig_o(auto_trig)
    );

    ais_state_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_trig_i(auto_trig),
        .man_ins_i  (man_ins_i),
        .active_o   (active)
    );

    ais_data_gate #(.DATA_W(DATA_W)) u_gate (
        .active_i(active),
        .data_i  (rx_data_i),
        .data_o  (rx_data_o)
    );

    always_comb ais_active_o = active;

    // R5: active status forces all ones on the data port
    p_all_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ais_active_o |-> (&rx_data_o));
    // R6: inactive status passes data through
    p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ais_active_o |-> (rx_data_o == rx_data_i));
    // R7: alarms with both controls off never activate
    p_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en_i && !man_ins_i) |=> !ais_active_o);
    // R8: manual release under a live auto trigger keeps AIS on
    p_no_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ais_active_o && auto_en_i && (los_i || oof_i || ais_det_i)) |=> ais_active_o);
endmodule

// File: tb/rx_ais_inserter_bench.sv
module rx_ais_inserter_bench;
    localparam int DW = 8;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic los = 0, oof = 0, aisd = 0, auto_en = 0, man = 0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic act;
    int checks = 0;
    int fails  = 0;
    logic exp_act = 1'b0;
    string act_tag = "R1";

    always #5 clk = ~clk;

    rx_ais_inserter #(.DATA_W(DW)) u_rx_ais_inserter (
        .clk(clk), .rst_n(rst_n), .los_i(los), .oof_i(oof), .ais_det_i(aisd),
        .auto_en_i(auto_en), .man_ins_i(man), .rx_data_i(din),
        .rx_data_o(dout), .ais_active_o(act));

    function automatic logic want_active(logic m, logic a, logic l, logic o, logic s);
        return m | (a & (l | o | s));
    endfunction

    function automatic logic [DW-1:0] want_data(logic e, logic [DW-1:0] d);
        return e ? {DW{1'b1}} : d;
    endfunction

    task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic check_now();
        chk(act_tag, {{(DW-1){1'b0}}, act}, {{(DW-1){1'b0}}, exp_act});
        chk(exp_act ? "R5" : "R6", dout, want_data(exp_act, din));
    endtask

    // drive at negedge, step one edge, then check at the next negedge
    task automatic step(logic m, logic a, logic l, logic o, logic s, logic [DW-1:0] d);
        man = m; auto_en = a; los = l; oof = o; aisd = s;
        if (m)                   act_tag = "R3";
        else if (a && (l|o|s))   act_tag = "R2";
        else if (!a && (l|o|s))  act_tag = "R7";
        else                     act_tag = "R4";
        @(posedge clk);
        exp_act = want_active(m, a, l, o, s);
        @(negedge clk);
        din = d;
        #1;
        check_now();
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        din = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", {7'd0, act}, 8'd0);
        chk("R1", dout, 8'h5A);
        // R7 each alarm alone, controls off
        step(0,0,1,0,0,8'h11); step(0,0,0,1,0,8'h22); step(0,0,0,0,1,8'h33);
        // R2 each alarm alone with auto mode
        step(0,1,1,0,0,8'h44); step(0,1,0,0,0,8'h55);
        step(0,1,0,1,0,8'h66); step(0,1,0,0,1,8'h00);
        // R4 auto turned off while alarm persists
        step(0,0,0,0,1,8'h77);
        // R3 manual regardless of alarms
        step(1,0,0,0,0,8'h01);
        // R8 manual held under alarm, then released with alarm on
        step(1,1,1,0,0,8'h02);
        step(0,1,1,0,0,8'h03);
        chk("R8", {7'd0, act}, 8'd1);
        step(0,1,0,0,0,8'h04);
        // constrained random phase
        for (int i = 0; i < 2000; i++) begin
            logic [DW-1:0] d;
            d = DW'($urandom);
            step(($urandom % 6) == 0, $urandom_range(0,1) == 1,
                 ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 7) == 0, d);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule